// File: doc/BRIEF.md
# Timestamp Event Queue

This block gathers time-stamped event records from several producers and keeps them in a first-in first-out queue of sixteen records, where software can collect them. The producers are a software push strobe, eight asynchronous hardware capture pins, and transmit and receive frame markers. The markers come from frame logic elsewhere and carry their own sequence id, message type, source port and domain fields. Every accepted record is stamped with the free-running 64-bit time value `ts_now` of the cycle in which the record is written.

Software sees the oldest record as four 32-bit words. It retires that record with a one-cycle pop request, and the next record then becomes visible. A raw pending flag shows whether any record is waiting. An interrupt line gives the same flag gated by an interrupt enable. A sticky overflow flag records that at least one record was lost because the queue had no room.

Several producers may fire in the same clock cycle. In that case every record that fits is written in that cycle, in a fixed order, so no producer has to wait.

Top module: `tstamp_evq`

## Requirements
- R1: The queue holds at most DEPTH (default 16) records. Room is judged from the occupancy at the start of the cycle, and a pop in the same cycle does not add room. Records that find no room are dropped. A dropped record sets `overflow`, which stays set until reset.
- R2: Head word 1 carries sequence id in bits [15:0], message type in [19:16], event type in [23:20] and port number in [28:24]. Bits [31:29] read as zero.
- R3: Head word 0 is timestamp bits [31:0] and head word 3 is timestamp bits [63:32]. Head word 2 carries the 8-bit domain in bits [7:0], with the other bits zero. The timestamp is the `ts_now` value of the cycle in which the producer's request is presented to the queue.
- R4: Each cycle in which `sw_push` is high queues one record with event type 0, and with port, sequence id, message type and domain all zero.
- R5: `stat_raw` is 1 exactly while at least one record is held. `irq` equals `stat_raw` AND `irq_en`.
- R6: Holding `pop_req` high for one cycle while records are held removes the head record, and the next record becomes the head. A pop while the queue is empty has no effect.
- R7: Each pin `hw_pin[k]` passes through a two-flop synchronizer and is captured on its rising edge. A capture queues a record with event type 3, port number k+1 and other fields zero, but only if `cfg_ctrl[8+k]` is 1. A rising edge on a disabled pin queues nothing.
- R8: A transmit marker (`tx_mark_vld`) queues a record with event type 5 and its own fields. A receive marker queues a record with event type 4, but only when `cfg_ctrl[3]` is 1. When that bit is 0, receive markers are ignored.
- R9: Sources that fire in the same cycle are queued in this order: software push first, then pins in ascending index, then transmit, then receive.
- R10: While the queue is empty, all four head words read as zero.
- R11: After reset the queue is empty, and `stat_raw`, `irq` and `overflow` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ts_now | input | 64 | Current time value |
| cfg_ctrl | input | 16 | Control: bit 3 receive enable, bits 8..15 pin enables |
| irq_en | input | 1 | Interrupt enable |
| sw_push | input | 1 | Software push request, one record per high cycle |
| hw_pin | input | 8 | Asynchronous hardware capture pins |
| tx_mark_vld | input | 1 | Transmit marker valid |
| tx_seq_id | input | 16 | Transmit marker sequence id |
| tx_msg_type | input | 4 | Transmit marker message type |
| tx_port | input | 5 | Transmit marker port number |
| tx_domain | input | 8 | Transmit marker domain |
| rx_mark_vld | input | 1 | Receive marker valid |
| rx_seq_id | input | 16 | Receive marker sequence id |
| rx_msg_type | input | 4 | Receive marker message type |
| rx_port | input | 5 | Receive marker port number |
| rx_domain | input | 8 | Receive marker domain |
| pop_req | input | 1 | Retire head record |
| head_w0 | output | 32 | Head timestamp low word |
| head_w1 | output | 32 | Head sequence id, message type, event type, port |
| head_w2 | output | 32 | Head domain |
| head_w3 | output | 32 | Head timestamp high word |
| stat_raw | output | 1 | At least one record pending |
| irq | output | 1 | Pending flag gated by `irq_en` |
| overflow | output | 1 | Sticky lost-record flag |

## Verification
The assertions take nothing for granted about the pin inputs. They may toggle at any time relative to the clock, because the occupancy, pointer and edge-pulse properties hold for any stimulus once reset is released. They do assume that `ts_now` and the marker fields are sampled only in the cycle their valid is high, so the bench holds `ts_now` constant around each event to keep the expected timestamp exact. The bench holds each pin high, and then low, for several cycles, so every pulse gives exactly one edge after the synchronizer. It lines up same-cycle bursts with the two-cycle synchronizer delay, so that pin captures and direct strobes reach the queue together.

// File: rtl/evq_pkg.sv
package evq_pkg;

  typedef enum logic [3:0] {
    ET_PUSH = 4'd0,
    ET_ROLL = 4'd1,
    ET_HALF = 4'd2,
    ET_PIN  = 4'd3,
    ET_RX   = 4'd4,
    ET_TX   = 4'd5,
    ET_CMP  = 4'd6,
    ET_HOST = 4'd7
  } evq_etype_e;

  typedef struct packed {
    logic [63:0] ts;
    logic [7:0]  dom;
    logic [4:0]  port;
    evq_etype_e  etype;
    logic [3:0]  mtype;
    logic [15:0] seq;
  } evq_rec_t;

endpackage

// File: rtl/evq_pin_capture.sv
module evq_pin_capture #(
  parameter int NUM_PINS = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pin_async,
  input  logic [NUM_PINS-1:0] pin_en,
  output logic [NUM_PINS-1:0] rise
);

  for (genvar k = 0; k < NUM_PINS; k++) begin : g_pin
    logic s1_q, s2_q, s3_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1_q <= 1'b0;
        s2_q <= 1'b0;
        s3_q <= 1'b0;
      end else begin
        s1_q <= pin_async[k];
        s2_q <= s1_q;
        s3_q <= s2_q;
      end
    end

    assign rise[k] = s2_q & ~s3_q & pin_en[k];

    AST_RISE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      rise[k] |=> !rise[k]); // R7
  end

endmodule

// File: rtl/evq_fifo.sv
module evq_fifo
  import evq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int NSRC  = 11
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_vld,
  input  evq_rec_t        src_rec [NSRC],
  input  logic            pop,
  output evq_rec_t        head_rec,
  output logic            not_empty,
  output logic            overflow
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int OFF_W = $clog2(DEPTH + NSRC + 1);
  localparam logic [OFF_W-1:0] DEPTH_O = OFF_W'(DEPTH);

  evq_rec_t          mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr_q, wr_ptr_d, rd_ptr_q, rd_ptr_d;
  logic [CNT_W-1:0]  count_q, count_d;
  logic              ovf_q, ovf_d;
  logic [DEPTH-1:0]  we;
  evq_rec_t          wd [DEPTH];
  logic [OFF_W-1:0]  offs [NSRC];
  logic [OFF_W-1:0]  n_req, n_acc, free_o;
  logic              pop_do;

  // next-state: slot allocation in priority order, counters, flags
  always_comb begin
    logic [OFF_W-1:0] slot;
    logic [OFF_W-1:0] wsum;
    free_o = DEPTH_O - OFF_W'(count_q);
    n_req  = '0;
    for (int s = 0; s < NSRC; s++) begin
      offs[s] = n_req;
      n_req   = n_req + OFF_W'(src_vld[s]);
    end
    n_acc  = (n_req > free_o) ? free_o : n_req;
    pop_do = pop && (count_q != '0);

    we = '0;
    for (int i = 0; i < DEPTH; i++) wd[i] = src_rec[0];
    for (int s = 0; s < NSRC; s++) begin
      slot = OFF_W'(wr_ptr_q) + offs[s];
      if (slot >= DEPTH_O) slot = slot - DEPTH_O;
      if (src_vld[s] && (offs[s] < free_o)) begin
        we[slot[PTR_W-1:0]] = 1'b1;
        wd[slot[PTR_W-1:0]] = src_rec[s];
      end
    end

    wsum = OFF_W'(wr_ptr_q) + n_acc;
    if (wsum >= DEPTH_O) wsum = wsum - DEPTH_O;
    wr_ptr_d = wsum[PTR_W-1:0];

    if (pop_do) rd_ptr_d = (rd_ptr_q == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr_q + 1'b1;
    else        rd_ptr_d = rd_ptr_q;

    count_d = count_q + CNT_W'(n_acc) - CNT_W'(pop_do);
    ovf_d   = ovf_q | (n_req > free_o);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
      ovf_q    <= 1'b0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      count_q  <= count_d;
      ovf_q    <= ovf_d;
    end
  end

  // record storage: write enables only, no reset on the data array
  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (we[i]) mem[i] <= wd[i];
    end
  end

  assign head_rec  = mem[rd_ptr_q];
  assign not_empty = (count_q != '0);
  assign overflow  = ovf_q;

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= CNT_W'(DEPTH)); // R1
  AST_PTR_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    ((OFF_W'(rd_ptr_q) + OFF_W'(count_q)) % DEPTH_O) == OFF_W'(wr_ptr_q)); // R1
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |=> ovf_q); // R1
  AST_POP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && count_q == '0) |=> $stable(rd_ptr_q)); // R6

endmodule

// File: rtl/tstamp_evq.sv
module tstamp_evq
  import evq_pkg::*;
#(
  parameter int NUM_PINS = 8,
  parameter int DEPTH    = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [63:0]         ts_now,
  input  logic [NUM_PINS+7:0] cfg_ctrl,
  input  logic                irq_en,
  input  logic                sw_push,
  input  logic [NUM_PINS-1:0] hw_pin,
  input  logic                tx_mark_vld,
  input  logic [15:0]         tx_seq_id,
  input  logic [3:0]          tx_msg_type,
  input  logic [4:0]          tx_port,
  input  logic [7:0]          tx_domain,
  input  logic                rx_mark_vld,
  input  logic [15:0]         rx_seq_id,
  input  logic [3:0]          rx_msg_type,
  input  logic [4:0]          rx_port,
  input  logic [7:0]          rx_domain,
  input  logic                pop_req,
  output logic [31:0]         head_w0,
  output logic [31:0]         head_w1,
  output logic [31:0]         head_w2,
  output logic [31:0]         head_w3,
  output logic                stat_raw,
  output logic                irq,
  output logic                overflow
);

  localparam int NSRC    = NUM_PINS + 3;
  localparam int SRC_TX  = NUM_PINS + 1;
  localparam int SRC_RX  = NUM_PINS + 2;
  localparam int RX_EN_B = 3;
  localparam int PIN_EN0 = 8;

  logic [NUM_PINS-1:0] pin_rise;
  logic [NSRC-1:0]     src_vld;
  evq_rec_t            src_rec [NSRC];
  evq_rec_t            head_rec;
  logic                not_empty;
  logic                ctrl_unused;

  assign ctrl_unused = ^{cfg_ctrl[2:0], cfg_ctrl[7:4]};

  evq_pin_capture #(.NUM_PINS(NUM_PINS)) u_pins (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin_async (hw_pin),
    .pin_en    (cfg_ctrl[PIN_EN0 +: NUM_PINS]),
    .rise      (pin_rise)
  );

  // source table, index order is the same-cycle queueing priority
  always_comb begin
    for (int s = 0; s < NSRC; s++) begin
      src_rec[s]    = '0;
      src_rec[s].ts = ts_now;
    end
    src_vld[0]          = sw_push;
    src_rec[0].etype    = ET_PUSH;
    for (int k = 0; k < NUM_PINS; k++) begin
      src_vld[1+k]       = pin_rise[k];
      src_rec[1+k].etype = ET_PIN;
      src_rec[1+k].port  = 5'(k + 1);
    end
    src_vld[SRC_TX]       = tx_mark_vld;
    src_rec[SRC_TX].etype = ET_TX;
    src_rec[SRC_TX].seq   = tx_seq_id;
    src_rec[SRC_TX].mtype = tx_msg_type;
    src_rec[SRC_TX].port  = tx_port;
    src_rec[SRC_TX].dom   = tx_domain;
    src_vld[SRC_RX]       = rx_mark_vld & cfg_ctrl[RX_EN_B];
    src_rec[SRC_RX].etype = ET_RX;
    src_rec[SRC_RX].seq   = rx_seq_id;
    src_rec[SRC_RX].mtype = rx_msg_type;
    src_rec[SRC_RX].port  = rx_port;
    src_rec[SRC_RX].dom   = rx_domain;
  end

  evq_fifo #(.DEPTH(DEPTH), .NSRC(NSRC)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_vld   (src_vld),
    .src_rec   (src_rec),
    .pop       (pop_req),
    .head_rec  (head_rec),
    .not_empty (not_empty),
    .overflow  (overflow)
  );

  assign head_w0  = not_empty ? head_rec.ts[31:0] : '0;
  assign head_w1  = not_empty ? {3'b000, head_rec.port, head_rec.etype,
                                 head_rec.mtype, head_rec.seq} : '0;
  assign head_w2  = not_empty ? {24'h0, head_rec.dom} : '0;
  assign head_w3  = not_empty ? head_rec.ts[63:32] : '0;
  assign stat_raw = not_empty;
  assign irq      = not_empty & irq_en;

  AST_RX_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (!stat_raw && rx_mark_vld && !cfg_ctrl[RX_EN_B] && !tx_mark_vld
     && !sw_push && (pin_rise == '0)) |=> !stat_raw); // R8
  AST_EMPTY_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_raw |-> (head_w0 == '0 && head_w1 == '0 && head_w2 == '0 && head_w3 == '0)); // R10

endmodule

// File: tb/test_tstamp_evq.sv
module test_tstamp_evq;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [63:0] ts_now;
  logic [15:0] cfg_ctrl;
  logic        irq_en, sw_push;
  logic [7:0]  hw_pin;
  logic        tx_mark_vld, rx_mark_vld;
  logic [15:0] tx_seq_id, rx_seq_id;
  logic [3:0]  tx_msg_type, rx_msg_type;
  logic [4:0]  tx_port, rx_port;
  logic [7:0]  tx_domain, rx_domain;
  logic        pop_req, mon_pop, man_pop, mon_en;
  logic [31:0] head_w0, head_w1, head_w2, head_w3;
  logic        stat_raw, irq, overflow;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;
  logic [127:0] exp_w [$];
  string        exp_tag [$];

  always #4 clk = ~clk;
  assign pop_req = mon_pop | man_pop;

  tstamp_evq i_tstamp_evq (
    .clk(clk), .rst_n(rst_n), .ts_now(ts_now), .cfg_ctrl(cfg_ctrl), .irq_en(irq_en),
    .sw_push(sw_push), .hw_pin(hw_pin),
    .tx_mark_vld(tx_mark_vld), .tx_seq_id(tx_seq_id), .tx_msg_type(tx_msg_type),
    .tx_port(tx_port), .tx_domain(tx_domain),
    .rx_mark_vld(rx_mark_vld), .rx_seq_id(rx_seq_id), .rx_msg_type(rx_msg_type),
    .rx_port(rx_port), .rx_domain(rx_domain),
    .pop_req(pop_req), .head_w0(head_w0), .head_w1(head_w1), .head_w2(head_w2),
    .head_w3(head_w3), .stat_raw(stat_raw), .irq(irq), .overflow(overflow)
  );

  task automatic chk(bit ok, string tag, logic [127:0] act, logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [127:0] mk(logic [63:0] ts, logic [15:0] seq, logic [3:0] mt,
                                      logic [3:0] et, logic [4:0] pt, logic [7:0] dm);
    return {ts[63:32], 24'h0, dm, 3'b000, pt, et, mt, seq, ts[31:0]};
  endfunction

  task automatic expect_rec(logic [127:0] w, string tag);
    exp_w.push_back(w);
    exp_tag.push_back(tag);
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  // monitor: compares the head with the scoreboard and retires it
  always @(negedge clk) begin
    if (mon_en && stat_raw) begin
      logic [127:0] act, e;
      string t;
      act = {head_w3, head_w2, head_w1, head_w0};
      if (exp_w.size() == 0) chk(0, "R6 unexpected record", act, '0);
      else begin
        e = exp_w.pop_front();
        t = exp_tag.pop_front();
        chk(act === e, t, act, e);
      end
      mon_pop = 1'b1;
    end else begin
      mon_pop = 1'b0;
    end
  end

  task automatic drain(string tag);
    mon_en = 1'b1;
    repeat (40) step();
    mon_en = 1'b0;
    step();
    chk(exp_w.size() == 0, tag, 128'(exp_w.size()), '0);
    chk(stat_raw == 1'b0, "R6 empty after drain", 128'(stat_raw), '0);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R6 watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 0; ts_now = '0; cfg_ctrl = '0; irq_en = 0; sw_push = 0; hw_pin = '0;
    tx_mark_vld = 0; rx_mark_vld = 0; tx_seq_id = '0; rx_seq_id = '0;
    tx_msg_type = '0; rx_msg_type = '0; tx_port = '0; rx_port = '0;
    tx_domain = '0; rx_domain = '0; man_pop = 0; mon_pop = 0; mon_en = 0;
    repeat (3) step();
    rst_n = 1;
    step();

    // R11 / R10 reset state
    @(negedge clk);
    chk(stat_raw == 0, "R11 stat_raw", 128'(stat_raw), 0);
    chk(irq == 0, "R11 irq", 128'(irq), 0);
    chk(overflow == 0, "R11 overflow", 128'(overflow), 0);
    chk({head_w3, head_w2, head_w1, head_w0} == '0, "R10 empty head",
        {head_w3, head_w2, head_w1, head_w0}, '0);

    // R4 push, R5 pending and interrupt masking
    step();
    ts_now = 64'h0123_4567_89AB_CDEF;
    sw_push = 1;
    step();
    sw_push = 0;
    @(negedge clk);
    chk(stat_raw == 1, "R5 raw set", 128'(stat_raw), 1);
    chk(irq == 0, "R5 irq masked", 128'(irq), 0);
    irq_en = 1;
    @(negedge clk);
    chk(irq == 1, "R5 irq enabled", 128'(irq), 1);
    step();
    expect_rec(mk(ts_now, 0, 0, 4'd0, 0, 0), "R4 push record");
    drain("R4 drained");
    @(negedge clk);
    chk(irq == 0, "R5 irq clears when empty", 128'(irq), 0);
    step();

    // R7 pins, each enabled one at a time
    cfg_ctrl = 16'hFF00;
    mon_en = 1;
    for (int k = 0; k < 8; k++) begin
      ts_now = 64'hABCD_0000_0000_1000 + 64'(k);
      expect_rec(mk(ts_now, 0, 0, 4'd3, 5'(k + 1), 0), "R7 pin record");
      hw_pin[k] = 1;
      repeat (4) step();
      hw_pin[k] = 0;
      repeat (4) step();
    end
    drain("R7 pins drained");

    // R7 disabled pin
    cfg_ctrl = 16'hEF00;
    hw_pin[4] = 1;
    repeat (6) step();
    @(negedge clk);
    chk(stat_raw == 0, "R7 disabled pin ignored", 128'(stat_raw), 0);
    step();
    hw_pin[4] = 0;
    repeat (4) step();

    // R8 receive ignored when disabled
    cfg_ctrl = 16'hFF00;
    rx_mark_vld = 1; rx_seq_id = 16'h1234; rx_msg_type = 4'h2; rx_port = 5'd3; rx_domain = 8'h44;
    step();
    rx_mark_vld = 0;
    @(negedge clk);
    chk(stat_raw == 0, "R8 rx ignored", 128'(stat_raw), 0);
    step();

    // R2 R3 R8 transmit then receive with fields
    ts_now = 64'hFEDC_BA98_7654_3210;
    tx_mark_vld = 1; tx_seq_id = 16'hBEEF; tx_msg_type = 4'hA; tx_port = 5'd31; tx_domain = 8'hC5;
    expect_rec(mk(ts_now, 16'hBEEF, 4'hA, 4'd5, 5'd31, 8'hC5), "R2 tx record fields");
    step();
    tx_mark_vld = 0;
    cfg_ctrl = 16'hFF08;
    ts_now = 64'h8000_0001_0000_0002;
    rx_mark_vld = 1;
    expect_rec(mk(ts_now, 16'h1234, 4'h2, 4'd4, 5'd3, 8'h44), "R3 rx record fields");
    step();
    rx_mark_vld = 0;
    drain("R8 markers drained");

    // R9 same-cycle priority
    ts_now = 64'h0000_0042_0000_0777;
    expect_rec(mk(ts_now, 0, 0, 4'd0, 0, 0), "R9 push first");
    expect_rec(mk(ts_now, 0, 0, 4'd3, 5'd2, 0), "R9 pin 2 second");
    expect_rec(mk(ts_now, 0, 0, 4'd3, 5'd7, 0), "R9 pin 7 third");
    expect_rec(mk(ts_now, 16'h0011, 4'h1, 4'd5, 5'd1, 8'h01), "R9 tx fourth");
    expect_rec(mk(ts_now, 16'h0022, 4'h3, 4'd4, 5'd2, 8'h02), "R9 rx last");
    hw_pin = 8'b0100_0010;
    step();
    step();
    sw_push = 1;
    tx_mark_vld = 1; tx_seq_id = 16'h0011; tx_msg_type = 4'h1; tx_port = 5'd1; tx_domain = 8'h01;
    rx_mark_vld = 1; rx_seq_id = 16'h0022; rx_msg_type = 4'h3; rx_port = 5'd2; rx_domain = 8'h02;
    step();
    sw_push = 0; tx_mark_vld = 0; rx_mark_vld = 0; hw_pin = '0;
    drain("R9 burst drained");

    // R1 capacity and overflow
    @(negedge clk);
    chk(overflow == 0, "R1 no overflow yet", 128'(overflow), 0);
    step();
    sw_push = 1;
    for (int i = 0; i < 17; i++) begin
      ts_now = 64'h5000 + 64'(i);
      if (i < 16) expect_rec(mk(ts_now, 0, 0, 4'd0, 0, 0), "R1 kept record");
      step();
    end
    sw_push = 0;
    @(negedge clk);
    chk(overflow == 1, "R1 overflow set", 128'(overflow), 1);
    chk(stat_raw == 1, "R1 full raw", 128'(stat_raw), 1);
    step();
    drain("R1 sixteen drained");
    @(negedge clk);
    chk(overflow == 1, "R1 overflow sticky", 128'(overflow), 1);
    step();

    // R6 pop on empty has no effect
    man_pop = 1;
    step();
    man_pop = 0;
    @(negedge clk);
    chk(stat_raw == 0, "R6 pop empty", 128'(stat_raw), 0);
    step();
    ts_now = 64'h6666_0000_0000_6666;
    sw_push = 1;
    expect_rec(mk(ts_now, 0, 0, 4'd0, 0, 0), "R6 record after empty pop");
    step();
    sw_push = 0;
    drain("R6 drained");

    done = 1;
    summary();
    $finish;
  end

endmodule